// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Edge Interrupt

This block is a 16-pin general-purpose I/O port on a simple 16-bit memory-mapped bus. Software sets each pin's direction, the value to drive on output pins, which edge (rising or falling) counts on each input pin, and an interrupt mask. Pin inputs pass through a two-flop synchroniser and then an edge detector. A qualifying edge latches a bit in a status register. The single interrupt request is the OR of all status bits. Software clears status bits by writing ones to them.

Output enables come straight from the direction register. A pin switched from input to output therefore starts driving its stored output bit on the cycle after the write. Only half-word (16-bit) accesses are accepted. Any other access width reads as zero and leaves every register unchanged.

Top module: `gpio16_port`

## Requirements
- R1: After reset, direction and mask read 0xFFFF, status and data output read 0x0000, pin control reads 0xFFFF, irq_o is 0 and pin_oe_o is 0x0000.
- R2: pin_oe_o is the inverse of the direction register (direction bit 1 = input, 0 = output), and pin_out_o is 0 on every pin whose direction bit is 1.
- R3: When a direction bit is written from 1 to 0, the pin's previously stored data output bit appears on pin_out_o with pin_oe_o high in the cycle after the write.
- R4: A read of the data input register returns the synchronised pin levels ANDed with the pin control register.
- R5: On a pin whose edge-select bit is 1, a rising edge sets its status bit and raises irq_o.
- R6: On a pin whose edge-select bit is 0, a falling edge sets its status bit, and a rising edge does not.
- R7: An edge sets no status bit when the pin's mask bit is 1 or its direction bit is 0.
- R8: Writing the status register clears the status bits that are 1 in the written data. irq_o is the OR of all status bits and falls once every status bit is clear.
- R9: Only accesses with size_i = 1 (16-bit) take effect. size_i = 0 (8-bit) and size_i = 2 (32-bit) reads return 0, and writes of those sizes change no register.
- R10: A pin level change shows in a data input read two clock edges after the change, and not one edge after it. A resulting status bit is set on the third edge.
- R11: Register offsets on addr_i: 0x00 data input (read-only), 0x04 data output, 0x08 direction, 0x0C edge select, 0x10 interrupt mask, 0x14 interrupt status, 0x18 pin control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access width: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational while a read is requested |
| pin_in_i | input | 16 | Pin input levels |
| pin_out_o | output | 16 | Pin output values |
| pin_oe_o | output | 16 | Pin output enables |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is an edge that arrives on a pin that cannot report it. The pin is either an output or masked, while neighbouring pins are armed and already hold status. The stimulus first configures a mix of output, masked and armed pins with different edge selections. It then toggles each pin in turn and reads status after exactly the synchroniser and detector latency. This shows which bits moved and which did not. The one-edge-early read shows that the synchroniser latency is exact.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DIN  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DOUT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_ESEL = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_PCTL = 8'h18;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_sel_i,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    // select 1: rising, 0: falling
    assign edge_o[i] = rise_sel_i[i] ? (lvl_i[i] & ~prev_q[i])
                                     : (~lvl_i[i] & prev_q[i]);
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio16_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      level_i,
  input  logic [W-1:0]      set_i,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      dout_o,
  output logic [W-1:0]      esel_o,
  output logic [W-1:0]      mask_o,
  output logic [W-1:0]      stat_o
);
  logic [W-1:0] dir_q, dout_q, esel_q, mask_q, stat_q, pctl_q;
  logic acc_ok, wr_en, rd_en;

  assign acc_ok = req_i && (size_i == SZ_HALF);
  assign wr_en  = acc_ok && we_i;
  assign rd_en  = acc_ok && !we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '1;
      dout_q <= '0;
      esel_q <= '0;
      mask_q <= '1;
      pctl_q <= '1;
    end else if (wr_en) begin
      unique case (addr_i)
        OFS_DOUT: dout_q <= wdata_i;
        OFS_DIR:  dir_q  <= wdata_i;
        OFS_ESEL: esel_q <= wdata_i;
        OFS_MASK: mask_q <= wdata_i;
        OFS_PCTL: pctl_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // new edges win over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else if (wr_en && addr_i == OFS_STAT) stat_q <= (stat_q & ~wdata_i) | set_i;
    else stat_q <= stat_q | set_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      unique case (addr_i)
        OFS_DIN:  rdata_o = level_i & pctl_q;
        OFS_DOUT: rdata_o = dout_q;
        OFS_DIR:  rdata_o = dir_q;
        OFS_ESEL: rdata_o = esel_q;
        OFS_MASK: rdata_o = mask_q;
        OFS_STAT: rdata_o = stat_q;
        OFS_PCTL: rdata_o = pctl_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign dir_o  = dir_q;
  assign dout_o = dout_q;
  assign esel_o = esel_q;
  assign mask_o = mask_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/gpio16_port.sv
module gpio16_port
  import gpio16_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      pin_in_i,
  output logic [W-1:0]      pin_out_o,
  output logic [W-1:0]      pin_oe_o,
  output logic              irq_o
);
  logic [W-1:0] lvl, edges, set, dir, dout, esel, mask, stat;

  gpio_sync #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_in_i),
    .q_o   (lvl)
  );

  gpio_edge #(.W(W)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (lvl),
    .rise_sel_i(esel),
    .edge_o    (edges)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .we_i   (we_i),
    .size_i (size_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .level_i(lvl),
    .set_i  (set),
    .dir_o  (dir),
    .dout_o (dout),
    .esel_o (esel),
    .mask_o (mask),
    .stat_o (stat)
  );

  // only unmasked input pins may report
  assign set       = edges & dir & ~mask;
  assign pin_oe_o  = ~dir;
  assign pin_out_o = dout & ~dir;
  assign irq_o     = |stat;
endmodule

// File: rtl/gpio16_port_chk.sv
module gpio16_port_chk
  import gpio16_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [1:0]        size_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [W-1:0]      rdata_o,
  input logic [W-1:0]      pin_out_o,
  input logic [W-1:0]      pin_oe_o,
  input logic [W-1:0]      dir,
  input logic [W-1:0]      mask,
  input logic [W-1:0]      stat,
  input logic [W-1:0]      dout
);
  assert_out_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_out_o & ~pin_oe_o) == '0);

  assert_status_qualified_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat & ~$past(stat) & ($past(mask) | ~$past(dir))) == '0));

  assert_bad_width_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && size_i != SZ_HALF) |=> ($stable(dout) && $stable(dir) && $stable(mask)));

  assert_bad_width_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i != SZ_HALF) |-> rdata_o == '0);
endmodule

bind gpio16_port gpio16_port_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .size_i   (size_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .pin_out_o(pin_out_o),
  .pin_oe_o (pin_oe_o),
  .dir      (dir),
  .mask     (mask),
  .stat     (stat),
  .dout     (dout)
);

// File: tb/gpio16_port_tb_top.sv
module gpio16_port_tb_top;
  import gpio16_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  size_i = 2'd1;
  logic [7:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [15:0] pin_in_i = '0;
  logic [15:0] pin_out_o, pin_oe_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit rd_live = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] v;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk_i = ~clk_i;

  gpio16_port dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .size_i   (size_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .pin_in_i (pin_in_i),
    .pin_out_o(pin_out_o),
    .pin_oe_o (pin_oe_o),
    .irq_o    (irq_o)
  );

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk_i) begin
    if (rd_live) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (rdata_o !== e.v) begin
        errors++;
        $display("FAIL %s: rdata act=%h exp=%h", e.tag, rdata_o, e.v);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] sz = 2'd1);
    @(posedge clk_i); #1;
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d; size_i = sz;
    @(posedge clk_i); #1;
    req_i = 1'b0; we_i = 1'b0; size_i = 2'd1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag,
                    input logic [1:0] sz = 2'd1);
    exp_t e;
    e.v = exp; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk_i); #1;
    req_i = 1'b1; we_i = 1'b0; addr_i = a; size_i = sz; rd_live = 1'b1;
    @(posedge clk_i); #1;
    req_i = 1'b0; rd_live = 1'b0; size_i = 2'd1;
  endtask

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    @(negedge clk_i);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic pins(input logic [15:0] v);
    pin_in_i = v;
    repeat (2) @(posedge clk_i);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1
    rd(OFS_DIR,  16'hFFFF, "R1 dir");
    rd(OFS_MASK, 16'hFFFF, "R1 mask");
    rd(OFS_STAT, 16'h0000, "R1 status");
    rd(OFS_DOUT, 16'h0000, "R1 dout");
    rd(OFS_PCTL, 16'hFFFF, "R1 pctl");
    chk({15'd0, irq_o}, 16'h0, "R1 irq");
    chk(pin_oe_o, 16'h0000, "R1 oe");
    // R2: stored outputs hidden while pins are inputs
    wr(OFS_DOUT, 16'hA5A5);
    chk(pin_out_o, 16'h0000, "R2 out gated");
    chk(pin_oe_o, 16'h0000, "R2 oe");
    // R3
    wr(OFS_DIR, 16'hFF00);
    chk(pin_oe_o, 16'h00FF, "R3 oe");
    chk(pin_out_o, 16'h00A5, "R3 out");
    // R4
    pins(16'h1234);
    rd(OFS_DIN, 16'h1234, "R4 din full");
    wr(OFS_PCTL, 16'h00FF);
    rd(OFS_DIN, 16'h0034, "R4 din pctl");
    wr(OFS_DIN, 16'hFFFF);
    rd(OFS_DIN, 16'h0034, "R11 din read-only");
    // arm: bit8/10/0 rising, bit9 falling; unmask 0,8,9
    pin_in_i = 16'h0000;
    repeat (5) @(posedge clk_i);
    wr(OFS_ESEL, 16'h0501);
    wr(OFS_MASK, 16'hFCFE);
    rd(OFS_STAT, 16'h0000, "R7 no status from masked edges");
    // R5
    pins(16'h0100);
    rd(OFS_STAT, 16'h0100, "R5 rising");
    chk({15'd0, irq_o}, 16'h1, "R5 irq");
    // R6
    pins(16'h0300);
    rd(OFS_STAT, 16'h0100, "R6 rising ignored");
    pins(16'h0100);
    rd(OFS_STAT, 16'h0300, "R6 falling");
    // R7
    pins(16'h0500);
    rd(OFS_STAT, 16'h0300, "R7 masked pin");
    pins(16'h0501);
    rd(OFS_STAT, 16'h0300, "R7 output pin");
    // R8
    wr(OFS_STAT, 16'h0100);
    rd(OFS_STAT, 16'h0200, "R8 partial clear");
    chk({15'd0, irq_o}, 16'h1, "R8 irq held");
    wr(OFS_STAT, 16'h0200);
    rd(OFS_STAT, 16'h0000, "R8 all clear");
    chk({15'd0, irq_o}, 16'h0, "R8 irq fell");
    // R9
    wr(OFS_DOUT, 16'hFFFF, 2'd0);
    rd(OFS_DOUT, 16'hA5A5, "R9 byte write ignored");
    wr(OFS_DIR, 16'h0000, 2'd2);
    rd(OFS_DIR, 16'hFF00, "R9 word write ignored");
    rd(OFS_DOUT, 16'h0000, "R9 word read zero", 2'd2);
    rd(OFS_DIR, 16'h0000, "R9 byte read zero", 2'd0);
    // R10
    wr(OFS_PCTL, 16'hFFFF);
    pin_in_i = 16'h8501;
    rd(OFS_DIN, 16'h0501, "R10 one edge old");
    rd(OFS_DIN, 16'h8501, "R10 two edges new");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog: act=timeout exp=done");
      end
    join_any
    @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule